// File: doc/BRIEF.md
# Dual Wiper Register Bank

This block keeps the digital state of two potentiometers. Each potentiometer owns a 6-bit wiper position and a small bank of four 8-bit stored settings. A command front end, which has already decoded the serial traffic, presents one request per cycle. The block executes that request and drives a one-hot tap-select vector per potentiometer toward the resistor array. The supported requests are reads and writes of the wiper or of a stored setting, copies between a setting and the wiper, copies that act on both potentiometers at once, and unit steps of the wiper.

The stored settings stand in for nonvolatile cells. They are modelled as flops, and every request that changes one of them holds `busy` high for a programmable number of cycles to mimic the write time. While `busy` is high the block refuses everything except a wiper read, and it answers each refused request with a one-cycle error strobe. Two resets are provided. A cold reset (`por_n`) loads every stored setting with a default value. A warm reset (`rst_n`) keeps the settings. When either reset is released, both wipers reload from their setting 0 on the first clock edge.

Top module: `dual_wiper_bank`

## Requirements
- R1: Each tap output is one-hot, and the bit set has the index of the wiper value. Bit 0 is the low terminal (wiper 00h) and bit 63 is the high terminal (wiper 3Fh).
- R2: Opcode 4'h0 reads the wiper of the pot given by `cmd_pot`. On the edge that accepts it, `rd_valid` pulses and `rd_data` carries the wiper value zero-extended to 8 bits.
- R3: Opcode 4'h1 loads the low 6 bits of `cmd_wdata` into the selected wiper.
- R4: Opcode 4'h3 writes `cmd_wdata` to setting `cmd_reg` of the selected pot and starts a busy period. Opcode 4'h2 returns that setting on `rd_data`, with `rd_valid` pulsing.
- R5: Opcode 4'h4 copies the low 6 bits of setting `cmd_reg` into the selected pot's wiper. It starts no busy period.
- R6: Opcode 4'h5 stores the selected wiper, zero-extended, into setting `cmd_reg`. Opcodes 4'h3, 4'h5 and 4'h7 each hold `busy` high for exactly NV_WRITE_CYCLES cycles after the accepting edge.
- R7: Opcode 4'h6 loads both wipers from their own setting `cmd_reg`. Opcode 4'h7 stores both wipers into setting `cmd_reg` of their own pot. `cmd_pot` is ignored for both.
- R8: Opcode 4'h8 moves the selected wiper up by one tap when `cmd_up` is 1 and down by one tap when it is 0. It holds at 3Fh going up and at 00h going down.
- R9: After either reset is released, the first edge loads each wiper from the low 6 bits of that pot's setting 0. `busy` is high until that edge, and a request presented on it is refused. A warm reset leaves all settings unchanged.
- R10: While `busy` is high, any request other than opcode 4'h0 is refused. A refused request pulses `cmd_err` one cycle after it is presented and changes no state. Opcodes 4'h9 to 4'hF are always refused.
- R11: A cold reset sets every setting to DR_INIT (default A5h), so the wipers come up at 25h after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, active low; reinitialises the settings |
| rst_n | input | 1 | Warm reset, active low; settings retained |
| cmd_valid | input | 1 | Request present this cycle |
| cmd_op | input | 4 | Request opcode |
| cmd_pot | input | 1 | Potentiometer select |
| cmd_reg | input | 2 | Setting index |
| cmd_wdata | input | 8 | Write value |
| cmd_up | input | 1 | Step direction, 1 = toward high terminal |
| busy | output | 1 | Write period or post-reset load in progress |
| cmd_err | output | 1 | Request refused (one-cycle pulse) |
| rd_valid | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 8 | Read result |
| tap0 | output | 64 | One-hot tap select, pot 0 |
| tap1 | output | 64 | One-hot tap select, pot 1 |

## Verification
Every result of an accepted request is due on the clock edge that samples the request. This covers read data, the error strobe, the new wiper and therefore the tap vectors. The busy flag stays high for the stated number of cycles after that edge. The bench drives each request on a falling edge and steps its reference model at the following rising edge. It then compares all outputs on the next falling edge, so each check looks at exactly one edge's worth of change. The busy window is probed at the last refused cycle and at the first accepted cycle, and the post-reset load is probed on the first edge after reset release.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  localparam logic [3:0] OP_RD_WCR = 4'h0;
  localparam logic [3:0] OP_WR_WCR = 4'h1;
  localparam logic [3:0] OP_RD_DR  = 4'h2;
  localparam logic [3:0] OP_WR_DR  = 4'h3;
  localparam logic [3:0] OP_DR2W   = 4'h4;
  localparam logic [3:0] OP_W2DR   = 4'h5;
  localparam logic [3:0] OP_GDR2W  = 4'h6;
  localparam logic [3:0] OP_GW2DR  = 4'h7;
  localparam logic [3:0] OP_STEP   = 4'h8;

  // per-pot action strobes produced by the controller
  typedef struct packed {
    logic wr_wcr;
    logic ld_dr;
    logic st_dr;
    logic wr_dr;
    logic step;
  } pot_ctl_t;
endpackage

// File: rtl/wbank_ctrl.sv
module wbank_ctrl
  import wbank_pkg::*;
#(
  parameter int NV_WRITE_CYCLES = 12,
  parameter int NPOT            = 2,
  localparam int CNT_W          = $clog2(NV_WRITE_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [3:0]            cmd_op,
  input  logic                  cmd_pot,
  output pot_ctl_t [NPOT-1:0]   ctl,
  output logic                  boot,
  output logic                  busy,
  output logic                  err_q,
  output logic                  rd_en,
  output logic                  rd_is_wcr
);
  logic [CNT_W-1:0] nv_cnt;
  logic             boot_q;
  logic             known_op, allowed, accept, nv_start;

  assign boot      = boot_q;
  assign busy      = boot_q | (nv_cnt != '0);
  assign known_op  = cmd_op <= OP_STEP;
  assign allowed   = !boot_q && ((nv_cnt == '0) || (cmd_op == OP_RD_WCR));
  assign accept    = cmd_valid && known_op && allowed;
  assign nv_start  = accept && (cmd_op == OP_WR_DR || cmd_op == OP_W2DR || cmd_op == OP_GW2DR);
  assign rd_en     = accept && (cmd_op == OP_RD_WCR || cmd_op == OP_RD_DR);
  assign rd_is_wcr = cmd_op == OP_RD_WCR;

  for (genvar p = 0; p < NPOT; p++) begin : g_pot_ctl
    logic sel;
    assign sel = cmd_pot == 1'(p);
    assign ctl[p].wr_wcr = accept && sel && (cmd_op == OP_WR_WCR);
    assign ctl[p].ld_dr  = accept && ((sel && cmd_op == OP_DR2W) || cmd_op == OP_GDR2W);
    assign ctl[p].st_dr  = accept && ((sel && cmd_op == OP_W2DR) || cmd_op == OP_GW2DR);
    assign ctl[p].wr_dr  = accept && sel && (cmd_op == OP_WR_DR);
    assign ctl[p].step   = accept && sel && (cmd_op == OP_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_cnt <= '0;
      boot_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      err_q  <= cmd_valid && !accept;
      if (nv_start)            nv_cnt <= CNT_W'(NV_WRITE_CYCLES);
      else if (nv_cnt != '0)   nv_cnt <= nv_cnt - 1'b1;
    end
  end

  // R10
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && cmd_op != OP_RD_WCR) |=> err_q);
  // R6
  nv_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |=> busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && nv_cnt > 1) |=> busy);
endmodule

// File: rtl/wbank_pot.sv
module wbank_pot
  import wbank_pkg::*;
#(
  parameter int WIPER_W            = 6,
  parameter int DATA_W             = 8,
  parameter int NREG               = 4,
  parameter logic [DATA_W-1:0] DR_INIT = 8'hA5,
  localparam int IDX_W             = $clog2(NREG)
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          rst_n,
  input  logic                          boot,
  input  pot_ctl_t                      ctl,
  input  logic [IDX_W-1:0]              idx,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          up,
  output logic [WIPER_W-1:0]            wcr,
  output logic [NREG-1:0][DATA_W-1:0]   dr
);
  localparam logic [WIPER_W-1:0] W_MAX = '1;

  function automatic logic [WIPER_W-1:0] step_wiper(input logic [WIPER_W-1:0] w, input logic dir_up);
    if (dir_up) return (w == W_MAX) ? w : w + 1'b1;
    else        return (w == '0)    ? w : w - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wcr <= '0;
    else if (boot)       wcr <= dr[0][WIPER_W-1:0];
    else if (ctl.wr_wcr) wcr <= wdata[WIPER_W-1:0];
    else if (ctl.ld_dr)  wcr <= dr[idx][WIPER_W-1:0];
    else if (ctl.step)   wcr <= step_wiper(wcr, up);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                dr[i] <= DR_INIT;
      else if (ctl.wr_dr && idx == IDX_W'(i))    dr[i] <= wdata;
      else if (ctl.st_dr && idx == IDX_W'(i))    dr[i] <= DATA_W'(wcr);
    end
  end

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && up && wcr == W_MAX && !boot) |=> wcr == W_MAX);
  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !up && wcr == '0 && !boot) |=> wcr == '0);
  // R9
  boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot |=> wcr == $past(dr[0][WIPER_W-1:0]));
endmodule

// File: rtl/wbank_tapdec.sv
module wbank_tapdec #(
  parameter int WIPER_W = 6,
  localparam int TAPS   = 1 << WIPER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIPER_W-1:0] wcr,
  output logic [TAPS-1:0]    tap
);
  always_comb tap = TAPS'(1) << wcr;

  // R1
  onehot_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap) == 1) && tap[wcr]);
endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank
  import wbank_pkg::*;
#(
  parameter int WIPER_W            = 6,
  parameter int DATA_W             = 8,
  parameter int NREG               = 4,
  parameter int NV_WRITE_CYCLES    = 12,
  parameter logic [DATA_W-1:0] DR_INIT = 8'hA5,
  localparam int TAPS              = 1 << WIPER_W,
  localparam int IDX_W             = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_op,
  input  logic               cmd_pot,
  input  logic [IDX_W-1:0]   cmd_reg,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic               cmd_up,
  output logic               busy,
  output logic               cmd_err,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [TAPS-1:0]    tap0,
  output logic [TAPS-1:0]    tap1
);
  localparam int NPOT = 2;

  logic                                   rst_c;
  pot_ctl_t [NPOT-1:0]                    ctl;
  logic                                   boot, rd_en, rd_is_wcr;
  logic [NPOT-1:0][WIPER_W-1:0]           wcr_a;
  logic [NPOT-1:0][NREG-1:0][DATA_W-1:0]  dr_a;
  logic [NPOT-1:0][TAPS-1:0]              tap_a;

  assign rst_c = por_n & rst_n;

  wbank_ctrl #(.NV_WRITE_CYCLES(NV_WRITE_CYCLES), .NPOT(NPOT)) u_ctrl (
    .clk(clk), .rst_n(rst_c), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .ctl(ctl), .boot(boot), .busy(busy),
    .err_q(cmd_err), .rd_en(rd_en), .rd_is_wcr(rd_is_wcr)
  );

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    wbank_pot #(.WIPER_W(WIPER_W), .DATA_W(DATA_W), .NREG(NREG), .DR_INIT(DR_INIT)) u_pot (
      .clk(clk), .por_n(por_n), .rst_n(rst_c), .boot(boot), .ctl(ctl[p]),
      .idx(cmd_reg), .wdata(cmd_wdata), .up(cmd_up),
      .wcr(wcr_a[p]), .dr(dr_a[p])
    );
    wbank_tapdec #(.WIPER_W(WIPER_W)) u_dec (
      .clk(clk), .rst_n(rst_c), .wcr(wcr_a[p]), .tap(tap_a[p])
    );
  end

  assign tap0 = tap_a[0];
  assign tap1 = tap_a[1];

  always_ff @(posedge clk or negedge rst_c) begin
    if (!rst_c) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_is_wcr ? DATA_W'(wcr_a[cmd_pot]) : dr_a[cmd_pot][cmd_reg];
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_c)
    (cmd_valid && cmd_op == OP_RD_WCR && !boot) |=> rd_valid);
endmodule

// File: tb/sim_dual_wiper_bank.sv
module sim_dual_wiper_bank;
  localparam int PERIOD = 10;
  localparam int NV     = 6;
  localparam logic [7:0] INIT = 8'hA5;

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_pot = 1'b0, cmd_up = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_reg = '0;
  logic [7:0] cmd_wdata = '0;
  logic busy, cmd_err, rd_valid;
  logic [7:0] rd_data;
  logic [63:0] tap0, tap1;

  int vectors = 0, fails = 0;

  logic [5:0] m_wcr [2];
  logic [7:0] m_dr  [2][4];
  int         m_cnt;
  bit         m_boot;
  bit         e_err, e_rdv;
  logic [7:0] e_rd;

  always #(PERIOD/2) clk = ~clk;

  dual_wiper_bank #(.NV_WRITE_CYCLES(NV), .DR_INIT(INIT)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_up(cmd_up),
    .busy(busy), .cmd_err(cmd_err), .rd_valid(rd_valid), .rd_data(rd_data),
    .tap0(tap0), .tap1(tap1)
  );

  function automatic logic [63:0] exp_tap(input logic [5:0] w);
    logic [63:0] t = '0;
    t[w] = 1'b1;
    return t;
  endfunction

  function automatic logic [5:0] exp_step(input logic [5:0] w, input bit upw);
    if (upw) return (w == 6'd63) ? 6'd63 : 6'(w + 6'd1);
    return (w == 6'd0) ? 6'd0 : 6'(w - 6'd1);
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'h0: return "R2";
      4'h1: return "R3";
      4'h2, 4'h3: return "R4";
      4'h4: return "R5";
      4'h5: return "R6";
      4'h6, 4'h7: return "R7";
      4'h8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " err"}, 64'(cmd_err), 64'(e_err));
    check({tag, " rd_valid"}, 64'(rd_valid), 64'(e_rdv));
    if (e_rdv) check({tag, " rd_data"}, 64'(rd_data), 64'(e_rd));
    check("R1 tap0", tap0, exp_tap(m_wcr[0]));
    check("R1 tap1", tap1, exp_tap(m_wcr[1]));
    check("R6 busy", 64'(busy), 64'(m_boot || m_cnt != 0));
  endtask

  task automatic model(input bit v, input logic [3:0] op, input bit p, input logic [1:0] r,
                       input logic [7:0] d, input bit upw);
    bit acc, nvs;
    logic [5:0] w0, w1;
    acc = v && (op <= 4'h8) && !m_boot && (m_cnt == 0 || op == 4'h0);
    e_err = v && !acc;
    e_rdv = acc && (op == 4'h0 || op == 4'h2);
    e_rd  = (op == 4'h0) ? {2'b00, m_wcr[p]} : m_dr[p][r];
    nvs = 1'b0;
    w0 = m_wcr[0]; w1 = m_wcr[1];
    if (m_boot) begin
      m_wcr[0] = m_dr[0][0][5:0];
      m_wcr[1] = m_dr[1][0][5:0];
      m_boot = 1'b0;
    end else if (acc) begin
      case (op)
        4'h1: m_wcr[p] = d[5:0];
        4'h3: begin m_dr[p][r] = d; nvs = 1'b1; end
        4'h4: m_wcr[p] = m_dr[p][r][5:0];
        4'h5: begin m_dr[p][r] = {2'b00, m_wcr[p]}; nvs = 1'b1; end
        4'h6: begin m_wcr[0] = m_dr[0][r][5:0]; m_wcr[1] = m_dr[1][r][5:0]; end
        4'h7: begin m_dr[0][r] = {2'b00, w0}; m_dr[1][r] = {2'b00, w1}; nvs = 1'b1; end
        4'h8: m_wcr[p] = exp_step(m_wcr[p], upw);
        default: ;
      endcase
    end
    if (nvs) m_cnt = NV;
    else if (m_cnt > 0) m_cnt--;
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic req(input bit v, input logic [3:0] op, input bit p, input logic [1:0] r,
                     input logic [7:0] d, input bit upw, input string tag);
    cmd_valid = v; cmd_op = op; cmd_pot = p; cmd_reg = r; cmd_wdata = d; cmd_up = upw;
    @(posedge clk);
    model(v, op, p, r, d, upw);
    @(negedge clk);
    cmd_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset(input bit cold);
    @(negedge clk);
    if (cold) por_n = 1'b0;
    rst_n = 1'b0;
    m_cnt = 0; m_boot = 1'b1; e_err = 0; e_rdv = 0;
    for (int p = 0; p < 2; p++) begin
      m_wcr[p] = '0;
      if (cold) for (int r = 0; r < 4; r++) m_dr[p][r] = INIT;
    end
    @(negedge clk);
    check_all(cold ? "R11 reset" : "R9 reset");
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic idle_until_free();
    while (m_cnt != 0) req(1'b0, 4'h0, 1'b0, 2'd0, 8'h00, 1'b0, "R6 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R11 cold reset, R9 request during the load edge is refused
    do_reset(1'b1);
    req(1'b1, 4'h1, 1'b0, 2'd0, 8'h11, 1'b0, "R9 boot refuse");
    check("R11 wiper init", 64'(tap0), exp_tap(6'h25));
    // R3 write wiper with upper bits set, R8 saturation both ways
    req(1'b1, 4'h1, 1'b0, 2'd0, 8'hFF, 1'b0, "R3");
    req(1'b1, 4'h8, 1'b0, 2'd0, 8'h00, 1'b1, "R8 hold high");
    req(1'b1, 4'h1, 1'b1, 2'd0, 8'hC0, 1'b0, "R3");
    req(1'b1, 4'h8, 1'b1, 2'd0, 8'h00, 1'b0, "R8 hold low");
    req(1'b1, 4'h8, 1'b1, 2'd0, 8'h00, 1'b1, "R8 up");
    req(1'b1, 4'h0, 1'b1, 2'd0, 8'h00, 1'b0, "R2");
    // R4 write then busy window edges, R10
    req(1'b1, 4'h3, 1'b1, 2'd0, 8'h5A, 1'b0, "R4");
    req(1'b1, 4'h0, 1'b0, 2'd0, 8'h00, 1'b0, "R10 read allowed");
    for (int i = 0; i < NV - 2; i++) req(1'b0, 4'h0, 1'b0, 2'd0, 8'h00, 1'b0, "R6 idle");
    req(1'b1, 4'h1, 1'b0, 2'd0, 8'h07, 1'b0, "R10 last busy");
    req(1'b1, 4'h1, 1'b0, 2'd0, 8'h07, 1'b0, "R6 free");
    req(1'b1, 4'h2, 1'b1, 2'd0, 8'h00, 1'b0, "R4 readback");
    // R7 global store then global load
    req(1'b1, 4'h7, 1'b0, 2'd3, 8'h00, 1'b0, "R7 store");
    idle_until_free();
    req(1'b1, 4'h6, 1'b1, 2'd1, 8'h00, 1'b0, "R7 load r1");
    req(1'b1, 4'h6, 1'b0, 2'd3, 8'h00, 1'b0, "R7 load r3");
    req(1'b1, 4'h9, 1'b0, 2'd0, 8'h00, 1'b0, "R10 bad op");
    // R9 warm reset keeps settings, wiper reloads from setting 0
    do_reset(1'b0);
    req(1'b0, 4'h0, 1'b0, 2'd0, 8'h00, 1'b0, "R9 load");
    req(1'b1, 4'h2, 1'b1, 2'd3, 8'h00, 1'b0, "R9 retained");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] op;
      bit v;
      v  = ($urandom % 4) != 0;
      op = 4'($urandom % 10);
      req(v, op, 1'($urandom), 2'($urandom), 8'($urandom), 1'($urandom), op_tag(op));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule